// File: doc/BRIEF.md
# Virtual-Channel Router Input Port with Four-Step Flit Pipeline

This block is one input port of a wormhole router that carries several virtual channels (VCs) on a single physical link. Each arriving flit carries a lane number, a two-bit kind, a destination coordinate and a payload. The flit is written into that lane's queue. The packet then moves through four steps in order: route computation, output-VC allocation, switch allocation and switch traversal. Only a head (or single) flit computes a route and claims an output VC. Body and tail flits reuse what the head obtained and only compete for the switch.

The switch allocator and the crossbar lie outside this block. Each lane raises a switch request together with its chosen output port, and the allocator answers with at most one grant per cycle. A granted flit leaves on the registered output one cycle later, tagged with its output port and output VC. Each flit that leaves a lane also returns one credit upstream. When a lane is streaming and its queue is empty, an arriving flit requests the switch in the same cycle it arrives. If it is granted, it never touches the queue storage.

Top module: `router_input_port`

## Requirements
- R1: After synchronous active-low reset, out_valid, every sw_req bit and every credit_out bit are 0.
- R2: The destination is {x, y}, with x in the upper X_W bits. The output port is chosen dimension-first. If x is above MY_X the port is 1 (+x). If x is below MY_X the port is 2 (−x). When x equals MY_X, y above MY_Y gives 3 (+y), y below MY_Y gives 4 (−y), and a match gives 0 (local).
- R3: A head flit that arrives in cycle t on an idle lane, with an output VC free, computes its route in t and is allocated in t+1. It requests the switch in t+2, and with a grant it appears on the output in t+3.
- R4: Body and tail flits do no route or VC step. A four-flit packet sent on consecutive cycles with no stalls leaves in cycles t+3 to t+6, in order, on one port and one output VC.
- R5: A lane whose request is refused keeps requesting with the same port in every following cycle. Its later flits are delayed by the same number of cycles.
- R6: A flit that reaches a streaming lane with an empty queue raises sw_req in its arrival cycle. With a grant it appears on the output in the next cycle.
- R7: credit_out[v] is 1 in exactly the cycles in which lane v's flit is granted, whether it came from storage or by the bypass. A lane never holds more than DEPTH flits.
- R8: The kind encoding is head=00, body=01, tail=10, single=11. A single flit performs all four steps and then leaves its lane idle.
- R9: VC allocation gives the lowest-numbered free output VC of the routed port. When several lanes wait, the lowest-numbered lane is served first. The output VC stays held until the cycle after the tail or single flit appears on the output. A head finding no free VC waits in allocation.
- R10: Lanes are independent: a stalled lane does not delay a flit of another lane that is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Flit present on the input |
| in_vc | input | VC_W | Lane of the arriving flit |
| in_kind | input | 2 | Flit kind (head/body/tail/single) |
| in_dest | input | X_W+Y_W | Destination {x, y} |
| in_data | input | DATA_W | Payload |
| sw_req | output | NUM_VC | Per-lane switch request |
| sw_port | output | NUM_VC*3 | Per-lane requested output port, lane v at bits [3v+2:3v] |
| sw_gnt | input | NUM_VC | Switch grant, at most one bit set, only on a requesting lane |
| credit_out | output | NUM_VC | One credit per flit leaving a lane |
| out_valid | output | 1 | Flit on the switch output |
| out_port | output | 3 | Output port of the flit |
| out_vc | output | OVC_W | Output VC of the flit |
| out_kind | output | 2 | Kind of the flit |
| out_dest | output | X_W+Y_W | Destination of the flit |
| out_data | output | DATA_W | Payload of the flit |

## Verification
The bench sweeps every destination of a 4x4 grid as single flits. A wrong comparison or a swapped axis would send flits to the wrong port, and a single flit that failed to release its VC would stall the next one. It checks the exact cycle of every output, credit and request for a clean packet, for a refused lane while a second lane passes it, and for a late body that must bypass the queue. A missing bypass would show up as a one-cycle delay, and a credit tied to the write would show up in the wrong cycle. A three-lane contention case for two output VCs shows whether an early release, a wrong VC choice or a wrong lane priority lets the third head leave too early or on the wrong VC.

// File: rtl/flit_rtr_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the router input port.
// Assumes a 5-port mesh router (local plus four directions).
package flit_rtr_pkg;
    typedef enum logic [1:0] {
        FK_HEAD   = 2'b00,
        FK_BODY   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        LANE_IDLE  = 2'b00,
        LANE_ALLOC = 2'b01,
        LANE_FLOW  = 2'b10
    } lane_state_e;

    localparam int PORT_W    = 3;
    localparam int NUM_PORTS = 5;
    localparam logic [PORT_W-1:0] P_LOCAL = 3'd0;
    localparam logic [PORT_W-1:0] P_XPOS  = 3'd1;
    localparam logic [PORT_W-1:0] P_XNEG  = 3'd2;
    localparam logic [PORT_W-1:0] P_YPOS  = 3'd3;
    localparam logic [PORT_W-1:0] P_YNEG  = 3'd4;
endpackage

// File: rtl/xy_route.sv
`timescale 1ns/1ps
// Dimension-ordered route computation: resolve x first, then y.
// Assumes the destination is packed as {x, y}. Purely combinational.
module xy_route
    import flit_rtr_pkg::*;
#(
    parameter int X_W  = 2,
    parameter int Y_W  = 2,
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  logic [X_W+Y_W-1:0] dest,
    output logic [PORT_W-1:0]  port
);
    logic [X_W-1:0] dx;
    logic [Y_W-1:0] dy;
    assign dx = dest[X_W+Y_W-1 -: X_W];
    assign dy = dest[Y_W-1:0];

    // Pick the output port from the coordinate comparison.
    always_comb begin
        if (dx > X_W'(MY_X))      port = P_XPOS;
        else if (dx < X_W'(MY_X)) port = P_XNEG;
        else if (dy > Y_W'(MY_Y)) port = P_YPOS;
        else if (dy < Y_W'(MY_Y)) port = P_YNEG;
        else                      port = P_LOCAL;
    end
endmodule

// File: rtl/ovc_table.sv
`timescale 1ns/1ps
// Output-VC ownership table and allocator for one input port.
// Serves the lowest-numbered requesting lane, handing it the lowest free
// VC of its port. Assumes at most one release per cycle.
module ovc_table
    import flit_rtr_pkg::*;
#(
    parameter int NUM_VC  = 2,
    parameter int OUT_VCS = 2,
    parameter int OVC_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VC-1:0] va_req,
    input  logic [PORT_W-1:0] va_port [NUM_VC],
    output logic [NUM_VC-1:0] va_gnt,
    output logic [OVC_W-1:0]  va_vc,
    input  logic              rel_en,
    input  logic [PORT_W-1:0] rel_port,
    input  logic [OVC_W-1:0]  rel_vc
);
    logic [OUT_VCS-1:0] busy [NUM_PORTS];
    logic               alloc_en;
    logic [PORT_W-1:0]  alloc_port;
    logic               lane_seen;

    // Pick the first requesting lane and the first free VC on its port.
    always_comb begin
        va_gnt     = '0;
        va_vc      = '0;
        alloc_en   = 1'b0;
        alloc_port = '0;
        lane_seen  = 1'b0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (!lane_seen && va_req[v]) begin
                lane_seen  = 1'b1;
                alloc_port = va_port[v];
                for (int o = 0; o < OUT_VCS; o++) begin
                    if (!alloc_en && (int'(va_port[v]) < NUM_PORTS)
                        && !busy[va_port[v]][o]) begin
                        alloc_en  = 1'b1;
                        va_vc     = OVC_W'(o);
                        va_gnt[v] = 1'b1;
                    end
                end
            end
        end
    end

    // Record allocations and clear VCs released by a departing tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) busy[p] <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                for (int o = 0; o < OUT_VCS; o++) begin
                    if (rel_en && rel_port == PORT_W'(p) && rel_vc == OVC_W'(o))
                        busy[p][o] <= 1'b0;
                    else if (alloc_en && alloc_port == PORT_W'(p) && va_vc == OVC_W'(o))
                        busy[p][o] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fr_vc_lane.sv
`timescale 1ns/1ps
// One virtual-channel lane: flit queue plus per-packet route/VC state.
// A head or single flit at the front triggers route computation, then VC
// allocation; the lane then requests the switch for each front flit until
// the tail leaves. With an empty queue the incoming flit is the front and
// may leave without being stored. Assumes upstream honours credits.
module fr_vc_lane
    import flit_rtr_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int FLIT_W = 22,
    parameter int OVC_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLIT_W-1:0] wr_flit,
    output logic [FLIT_W-1:0] front_flit,
    input  logic [PORT_W-1:0] rc_port,
    output logic              va_req,
    output logic [PORT_W-1:0] route,
    input  logic              va_gnt,
    input  logic [OVC_W-1:0]  va_vc,
    output logic [OVC_W-1:0]  ovc,
    output logic              sw_req,
    input  logic              sw_gnt,
    output logic              leave
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [FLIT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt;
    lane_state_e       st;
    logic              empty, front_valid, bypass, do_write, do_read;
    flit_kind_e        kind;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Front of the lane: stored flit, or the arriving one when empty.
    always_comb begin
        empty       = (cnt == '0);
        front_valid = !empty || wr_en;
        front_flit  = empty ? wr_flit : mem[rd_ptr];
        kind        = flit_kind_e'(front_flit[FLIT_W-1 -: 2]);
        va_req      = (st == LANE_ALLOC);
        sw_req      = (st == LANE_FLOW) && front_valid;
        leave       = sw_req && sw_gnt;
        bypass      = leave && empty;
        do_write    = wr_en && !bypass;
        do_read     = leave && !empty;
    end

    // Queue storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_write) mem[wr_ptr] <= wr_flit;
    end

    // Queue pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_write) wr_ptr <= bump(wr_ptr);
            if (do_read)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CNT_W'(do_write) - CNT_W'(do_read);
        end
    end

    // Packet state: route step, VC step, then streaming until the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= LANE_IDLE;
            route <= '0;
            ovc   <= '0;
        end else begin
            unique case (st)
                LANE_IDLE: if (front_valid && (kind == FK_HEAD || kind == FK_SINGLE)) begin
                    route <= rc_port;
                    st    <= LANE_ALLOC;
                end
                LANE_ALLOC: if (va_gnt) begin
                    ovc <= va_vc;
                    st  <= LANE_FLOW;
                end
                LANE_FLOW: if (leave && (kind == FK_TAIL || kind == FK_SINGLE))
                    st <= LANE_IDLE;
                default: st <= LANE_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/router_input_port.sv
`timescale 1ns/1ps
// Router input port: NUM_VC lanes, each with its own route unit, a shared
// output-VC table, and the switch-traversal register. Assumes the external
// switch allocator grants at most one requesting lane per cycle.
module router_input_port
    import flit_rtr_pkg::*;
#(
    parameter int NUM_VC  = 2,
    parameter int DEPTH   = 4,
    parameter int DATA_W  = 16,
    parameter int X_W     = 2,
    parameter int Y_W     = 2,
    parameter int MY_X    = 1,
    parameter int MY_Y    = 1,
    parameter int OUT_VCS = 2,
    localparam int DEST_W = X_W + Y_W,
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int OVC_W  = (OUT_VCS > 1) ? $clog2(OUT_VCS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [VC_W-1:0]          in_vc,
    input  logic [1:0]               in_kind,
    input  logic [DEST_W-1:0]        in_dest,
    input  logic [DATA_W-1:0]        in_data,
    output logic [NUM_VC-1:0]        sw_req,
    output logic [NUM_VC*PORT_W-1:0] sw_port,
    input  logic [NUM_VC-1:0]        sw_gnt,
    output logic [NUM_VC-1:0]        credit_out,
    output logic                     out_valid,
    output logic [PORT_W-1:0]        out_port,
    output logic [OVC_W-1:0]         out_vc,
    output logic [1:0]               out_kind,
    output logic [DEST_W-1:0]        out_dest,
    output logic [DATA_W-1:0]        out_data
);
    localparam int FLIT_W = 2 + DEST_W + DATA_W;

    logic [FLIT_W-1:0] in_flit;
    logic [FLIT_W-1:0] lane_front [NUM_VC];
    logic [PORT_W-1:0] lane_rc    [NUM_VC];
    logic [PORT_W-1:0] lane_route [NUM_VC];
    logic [OVC_W-1:0]  lane_ovc   [NUM_VC];
    logic [NUM_VC-1:0] lane_va_req, lane_va_gnt, lane_leave;
    logic [OVC_W-1:0]  va_vc;
    logic [FLIT_W-1:0] sel_flit;
    logic [PORT_W-1:0] sel_port;
    logic [OVC_W-1:0]  sel_vc;
    logic              rel_en;

    assign in_flit    = {in_kind, in_dest, in_data};
    assign credit_out = lane_leave;

    for (genvar g = 0; g < NUM_VC; g++) begin : g_lane
        fr_vc_lane #(.DEPTH(DEPTH), .FLIT_W(FLIT_W), .OVC_W(OVC_W)) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (in_valid && (in_vc == VC_W'(g))),
            .wr_flit    (in_flit),
            .front_flit (lane_front[g]),
            .rc_port    (lane_rc[g]),
            .va_req     (lane_va_req[g]),
            .route      (lane_route[g]),
            .va_gnt     (lane_va_gnt[g]),
            .va_vc      (va_vc),
            .ovc        (lane_ovc[g]),
            .sw_req     (sw_req[g]),
            .sw_gnt     (sw_gnt[g]),
            .leave      (lane_leave[g])
        );
        xy_route #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) i_rc (
            .dest (lane_front[g][DEST_W+DATA_W-1 -: DEST_W]),
            .port (lane_rc[g])
        );
        assign sw_port[g*PORT_W +: PORT_W] = lane_route[g];
    end

    ovc_table #(.NUM_VC(NUM_VC), .OUT_VCS(OUT_VCS), .OVC_W(OVC_W)) i_ovc (
        .clk      (clk),
        .rst_n    (rst_n),
        .va_req   (lane_va_req),
        .va_port  (lane_route),
        .va_gnt   (lane_va_gnt),
        .va_vc    (va_vc),
        .rel_en   (rel_en),
        .rel_port (out_port),
        .rel_vc   (out_vc)
    );

    // Release the output VC as the packet's last flit traverses.
    assign rel_en = out_valid && (out_kind == FK_TAIL || out_kind == FK_SINGLE);

    // Select the flit of the granted lane.
    always_comb begin
        sel_flit = '0;
        sel_port = '0;
        sel_vc   = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (lane_leave[v]) begin
                sel_flit = lane_front[v];
                sel_port = lane_route[v];
                sel_vc   = lane_ovc[v];
            end
        end
    end

    // Switch-traversal register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_vc    <= '0;
            out_kind  <= '0;
            out_dest  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= |lane_leave;
            if (|lane_leave) begin
                out_port <= sel_port;
                out_vc   <= sel_vc;
                {out_kind, out_dest, out_data} <= sel_flit;
            end
        end
    end
endmodule

// File: rtl/router_input_port_chk.sv
`timescale 1ns/1ps
// Protocol checker for router_input_port, attached by bind.
// Tracks per-lane occupancy from arrivals and credits.
module router_input_port_chk #(
    parameter int NUM_VC = 2,
    parameter int DEPTH  = 4,
    parameter int VC_W   = 1,
    parameter int PORT_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [VC_W-1:0]          in_vc,
    input logic [NUM_VC-1:0]        sw_req,
    input logic [NUM_VC*PORT_W-1:0] sw_port,
    input logic [NUM_VC-1:0]        sw_gnt,
    input logic [NUM_VC-1:0]        credit_out,
    input logic                     out_valid
);
    logic [7:0] occ [NUM_VC];

    // Occupancy model per lane: arrivals minus departures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VC; v++) occ[v] <= '0;
        end else begin
            for (int v = 0; v < NUM_VC; v++)
                occ[v] <= occ[v] + 8'(in_valid && in_vc == VC_W'(v)) - 8'(credit_out[v]);
        end
    end

    AST_GRANT_TRAVERSES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_req & sw_gnt)) |=> out_valid);  // R3
    AST_TRAVERSE_HAD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(|credit_out));  // R7

    for (genvar g = 0; g < NUM_VC; g++) begin : g_lane_chk
        AST_STALL_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_req[g] && !sw_gnt[g]) |=> sw_req[g]);  // R5
        AST_STALL_KEEPS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_req[g] && !sw_gnt[g]) |=> $stable(sw_port[g*PORT_W +: PORT_W]));  // R5
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            occ[g] <= 8'(DEPTH));  // R7
    end
endmodule

bind router_input_port router_input_port_chk #(
    .NUM_VC (NUM_VC),
    .DEPTH  (DEPTH),
    .VC_W   (VC_W),
    .PORT_W (flit_rtr_pkg::PORT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_vc      (in_vc),
    .sw_req     (sw_req),
    .sw_port    (sw_port),
    .sw_gnt     (sw_gnt),
    .credit_out (credit_out),
    .out_valid  (out_valid)
);

// File: tb/test_router_input_port.sv
`timescale 1ns/1ps
// Scenario bench: each scenario fills per-cycle stimulus and expected
// tables, runs, and compares every cycle of the logged outputs.
module test_router_input_port;
    localparam int NV = 3, DEPTH = 4, DW = 8, XW = 2, YW = 2, OV = 2;
    localparam int N = 80;

    logic           clk = 0, rst_n = 0;
    logic           in_valid = 0;
    logic [1:0]     in_vc = 0, in_kind = 0;
    logic [3:0]     in_dest = 0;
    logic [DW-1:0]  in_data = 0;
    logic [NV-1:0]  sw_req, sw_gnt, credit_out;
    logic [NV*3-1:0] sw_port;
    logic           out_valid;
    logic [2:0]     out_port;
    logic [0:0]     out_vc;
    logic [1:0]     out_kind;
    logic [3:0]     out_dest;
    logic [DW-1:0]  out_data;
    logic [NV-1:0]  allow = '1;

    int checks = 0, fails = 0, cyc_cnt = 0, base = 0;
    bit logging = 0;

    logic        s_v [N];
    logic [1:0]  s_vc [N], s_k [N];
    logic [3:0]  s_d [N];
    logic [7:0]  s_dat [N];
    logic [2:0]  s_al [N];
    logic        e_v [N], lg_v [N];
    logic [13:0] e_f [N], lg_f [N];
    logic [2:0]  e_cr [N], lg_cr [N], e_rq [N], lg_rq [N];

    router_input_port #(.NUM_VC(NV), .DEPTH(DEPTH), .DATA_W(DW), .X_W(XW), .Y_W(YW),
                        .MY_X(1), .MY_Y(2), .OUT_VCS(OV)) i_router_input_port (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_kind(in_kind),
        .in_dest(in_dest), .in_data(in_data), .sw_req(sw_req), .sw_port(sw_port),
        .sw_gnt(sw_gnt), .credit_out(credit_out), .out_valid(out_valid),
        .out_port(out_port), .out_vc(out_vc), .out_kind(out_kind),
        .out_dest(out_dest), .out_data(out_data));

    always #5 clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // Allocator model: lowest-numbered allowed requesting lane wins.
    always_comb begin
        logic taken;
        taken  = 1'b0;
        sw_gnt = '0;
        for (int v = 0; v < NV; v++)
            if (!taken && sw_req[v] && allow[v]) begin
                sw_gnt[v] = 1'b1;
                taken     = 1'b1;
            end
    end

    // Log outputs mid-cycle.
    always @(negedge clk) begin
        if (logging && (cyc_cnt - base) < N) begin
            lg_v[cyc_cnt - base]  <= out_valid;
            lg_f[cyc_cnt - base]  <= {out_port, out_vc, out_kind, out_data};
            lg_cr[cyc_cnt - base] <= credit_out;
            lg_rq[cyc_cnt - base] <= sw_req;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int port_of(input int x, input int y);
        if (x > 1) return 1;
        if (x < 1) return 2;
        if (y > 2) return 3;
        if (y < 2) return 4;
        return 0;
    endfunction

    task automatic clear_scn();
        for (int i = 0; i < N; i++) begin
            s_v[i] = 0; s_vc[i] = 0; s_k[i] = 0; s_d[i] = 0; s_dat[i] = 0; s_al[i] = '1;
            e_v[i] = 0; e_f[i] = 0; e_cr[i] = 0; e_rq[i] = 0;
            lg_v[i] = 0; lg_f[i] = 0; lg_cr[i] = 0; lg_rq[i] = 0;
        end
    endtask

    task automatic put(input int c, input int lane, input int kind, input int x,
                       input int y, input int data);
        s_v[c] = 1; s_vc[c] = 2'(lane); s_k[c] = 2'(kind);
        s_d[c] = {2'(x), 2'(y)}; s_dat[c] = 8'(data);
    endtask

    // Expected output in cycle c; its grant, credit and request one cycle earlier.
    task automatic want(input int c, input int lane, input int port, input int vc,
                        input int kind, input int data);
        e_v[c] = 1;
        e_f[c] = {3'(port), 1'(vc), 2'(kind), 8'(data)};
        e_cr[c-1][lane] = 1'b1;
        e_rq[c-1][lane] = 1'b1;
    endtask

    task automatic run(input int n);
        base = cyc_cnt;
        logging = 1;
        for (int c = 0; c < n; c++) begin
            in_valid = s_v[c]; in_vc = s_vc[c]; in_kind = s_k[c];
            in_dest = s_d[c]; in_data = s_dat[c]; allow = s_al[c];
            @(posedge clk); #1;
        end
        logging = 0;
        in_valid = 0; allow = '1;
    endtask

    task automatic verify(input int n, input string t_out, input string t_req);
        for (int c = 0; c < n; c++) begin
            chk(lg_v[c] == e_v[c], t_out, $sformatf("out_valid c%0d", c), lg_v[c], e_v[c]);
            if (e_v[c])
                chk(lg_f[c] == e_f[c], t_out, $sformatf("port/vc/kind/data c%0d", c),
                    lg_f[c], e_f[c]);
            chk(lg_cr[c] == e_cr[c], "R7", $sformatf("credit_out c%0d", c), lg_cr[c], e_cr[c]);
            chk(lg_rq[c] == e_rq[c], t_req, $sformatf("sw_req c%0d", c), lg_rq[c], e_rq[c]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
        chk(sw_req == 0, "R1", "sw_req", sw_req, 0);
        chk(credit_out == 0, "R1", "credit_out", credit_out, 0);
        @(posedge clk); #1;

        // R2 R8: single flits to every destination, one every 4 cycles
        clear_scn();
        for (int i = 0; i < 16; i++) begin
            put(4*i, 0, 3, i >> 2, i & 3, i);
            want(4*i + 3, 0, port_of(i >> 2, i & 3), 0, 3, i);
        end
        run(68);
        verify(68, "R2 R8", "R3");

        // R3 R4: four-flit packet, no stalls
        clear_scn();
        put(0, 0, 0, 3, 0, 8'h10); put(1, 0, 1, 3, 0, 8'h11);
        put(2, 0, 1, 3, 0, 8'h12); put(3, 0, 2, 3, 0, 8'h13);
        for (int k = 0; k < 4; k++) want(3 + k, 0, 1, 0, (k == 0) ? 0 : (k == 3) ? 2 : 1, 8'h10 + k);
        run(12);
        verify(12, "R3 R4", "R4");

        // R5 R10: lane 0 refused for cycles 2..5, lane 1 single passes it
        clear_scn();
        put(0, 0, 0, 1, 3, 8'h20); put(1, 1, 3, 1, 2, 8'h2F);
        put(2, 0, 1, 1, 3, 8'h21); put(3, 0, 1, 1, 3, 8'h22); put(4, 0, 2, 1, 3, 8'h23);
        for (int c = 2; c <= 5; c++) begin
            s_al[c] = 3'b110;
            e_rq[c][0] = 1'b1;
        end
        want(4, 1, 0, 0, 3, 8'h2F);
        for (int k = 0; k < 4; k++) want(7 + k, 0, 3, 0, (k == 0) ? 0 : (k == 3) ? 2 : 1, 8'h20 + k);
        run(14);
        verify(14, "R5 R10", "R5");

        // R6: late body and tail reach an empty streaming lane
        clear_scn();
        put(0, 1, 0, 0, 0, 8'h30); put(1, 1, 1, 0, 0, 8'h31);
        put(6, 1, 1, 0, 0, 8'h32); put(8, 1, 2, 0, 0, 8'h33);
        want(3, 1, 2, 0, 0, 8'h30); want(4, 1, 2, 0, 1, 8'h31);
        want(7, 1, 2, 0, 1, 8'h32); want(9, 1, 2, 0, 2, 8'h33);
        run(14);
        verify(14, "R6", "R6");

        // R9: three lanes contend for the two output VCs of port +x
        clear_scn();
        put(0, 0, 0, 2, 2, 8'h40); put(1, 1, 0, 2, 2, 8'h50); put(2, 2, 0, 2, 2, 8'h60);
        put(4, 0, 2, 2, 2, 8'h41); put(5, 1, 2, 2, 2, 8'h51); put(8, 2, 2, 2, 2, 8'h61);
        want(3, 0, 1, 0, 0, 8'h40); want(4, 1, 1, 1, 0, 8'h50);
        want(5, 0, 1, 0, 2, 8'h41); want(6, 1, 1, 1, 2, 8'h51);
        want(8, 2, 1, 0, 0, 8'h60); want(9, 2, 1, 0, 2, 8'h61);
        run(14);
        verify(14, "R9", "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule